// File: doc/BRIEF.md
# One-Hot Local Decoder with Complement

This block turns a compact binary selector into a one-hot control word, for the memory bits that steer one branch of a multi-level multiplexer. The configuration storage holds only the short binary code. The decoder expands it into the wide select word that the pass gates need, and it also gives the bitwise inverse of that word for gates that need both polarities.

The output width N is the number of memory bits in the branch. The selector width is derived from N. A selector value that no output bit can represent does not give an all-zero word. It picks the topmost output instead, so the branch is never left with no input selected. The single-output case N = 1 becomes a wire and an inverter. The block is purely combinational: it has no clock, no reset and no stored state. A fabric places one instance for each distinct branch width it uses.

Top module: `ohd_local_decoder`

## Requirements
- R1: The selector port `addr_i` is ceil(log2(N)) bits wide, with a minimum of 1 bit. This gives 1 bit for N=1 and N=2, 2 bits for N=3, and 3 bits for N=5 and N=8.
- R2: For a selector value i with 0 <= i < N, bit i of `data_o` is 1 and every other bit is 0. Bit 0 is the least significant bit.
- R3: For N >= 2, any selector value of N or above sets only bit N-1 of `data_o`, the most significant output.
- R4: `data_n_o` equals the bitwise complement of `data_o` for every selector value.
- R5: For N = 1, `data_o` equals the selector bit and `data_n_o` equals its inverse.
- R6: For N >= 2, `data_o` has exactly one bit set for every selector value, including values outside 0..N-1.
- R7: The outputs depend only on the present selector value. A value applied again after other values gives the same outputs, and a new value shows at the outputs within the same clock cycle in which it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | max(1, ceil(log2(N))) | Binary selector code |
| data_o | output | N | One-hot select word, bit i set for selector value i |
| data_n_o | output | N | Bitwise complement of data_o |

## Verification
The checker assumes that the selector carries only known 0/1 values, and it skips its checks while any selector bit is unknown. It also assumes the outputs have settled from the present selector value, because the block has no register to sample. The bench sweeps every encodable selector value for N of 1, 2, 3, 5 and 8, so every value it drives is a defined code. Each value is driven on a falling clock edge and the outputs are read one nanosecond later, once the logic has settled. The out-of-range values (3 for N=3; 5, 6 and 7 for N=5) fall inside the sweep.

// File: rtl/ohd_pkg.sv
package ohd_pkg;

  // Selector width for an N-bit one-hot word, never below one bit.
  function automatic int addr_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

endpackage

// File: rtl/ohd_onehot_core.sv
// Decoder for N >= 2. A code that is too large selects the top bit.
module ohd_onehot_core #(
  parameter int N  = 5,
  parameter int AW = ohd_pkg::addr_width(N)
) (
  input  logic [AW-1:0] sel,
  output logic [N-1:0]  word
);

  localparam int TOP = N - 1;

  always_comb begin
    word = '0;
    for (int i = 0; i < N; i++) begin
      if (int'(sel) == i) word[i] = 1'b1;
    end
    if (int'(sel) > TOP) word[TOP] = 1'b1;
  end

endmodule

// File: rtl/ohd_invert.sv
// Bitwise inverse stage that drives the complementary select word.
module ohd_invert #(
  parameter int W = 5
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);

  assign y = ~a;

endmodule

// File: rtl/ohd_local_decoder.sv
module ohd_local_decoder #(
  parameter  int N  = 5,
  localparam int AW = ohd_pkg::addr_width(N)
) (
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  data_o,
  output logic [N-1:0]  data_n_o
);

  logic [N-1:0] word;

  generate
    if (N == 1) begin : g_wire
      // A single memory bit needs no decoding.
      assign word = addr_i[0];
    end else begin : g_decode
      ohd_onehot_core #(.N(N), .AW(AW)) u_core (
        .sel  (addr_i),
        .word (word)
      );
    end
  endgenerate

  ohd_invert #(.W(N)) u_inv (
    .a (word),
    .y (data_n_o)
  );

  assign data_o = word;

endmodule

// File: rtl/ohd_local_decoder_chk.sv
module ohd_local_decoder_chk #(
  parameter  int N  = 5,
  localparam int AW = ohd_pkg::addr_width(N)
) (
  input logic [AW-1:0] addr,
  input logic [N-1:0]  data,
  input logic [N-1:0]  data_n
);

  always_comb begin
    if (!$isunknown(addr)) begin
      assert_complement_R4: assert ((data ^ data_n) == '1)
        else $error("outputs are not complements");
    end
  end

  generate
    if (N == 1) begin : g_one
      always_comb begin
        if (!$isunknown(addr)) begin
          assert_passthrough_R5: assert (data[0] == addr[0])
            else $error("single-bit output does not follow the selector");
        end
      end
    end else begin : g_many
      always_comb begin
        if (!$isunknown(addr)) begin
          assert_onehot_R6: assert ($countones(data) == 1)
            else $error("output is not one-hot");
          if (int'(addr) < N) begin
            assert_in_range_R2: assert (data[int'(addr)])
              else $error("selected bit is clear");
          end else begin
            assert_clamp_top_R3: assert (data[N-1])
              else $error("out-of-range code does not select the top bit");
          end
        end
      end
    end
  endgenerate

endmodule

bind ohd_local_decoder ohd_local_decoder_chk #(.N(N)) u_chk (
  .addr   (addr_i),
  .data   (data_o),
  .data_n (data_n_o)
);

// File: tb/tb_ohd_local_decoder.sv
`timescale 1ns/1ps
module tb_ohd_local_decoder;

  localparam int NCFG = 5;
  localparam int NS [NCFG] = '{1, 2, 3, 5, 8};

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int fails  = 0;
  logic [NCFG-1:0] done = '0;

  function automatic int bench_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w = w + 1;
    return w;
  endfunction

  genvar g;
  generate
    for (g = 0; g < NCFG; g++) begin : g_cfg
      localparam int NN = NS[g];
      localparam int AW = bench_width(NN);
      logic [AW-1:0] a = '0;
      logic [NN-1:0] d;
      logic [NN-1:0] dn;

      ohd_local_decoder #(.N(NN)) dut (
        .addr_i   (a),
        .data_o   (d),
        .data_n_o (dn)
      );

      function automatic logic [NN-1:0] expect_word(input int v);
        logic [NN-1:0] e;
        e = '0;
        if (NN == 1) e[0] = v[0];
        else e[(v < NN) ? v : NN - 1] = 1'b1;
        return e;
      endfunction

      task automatic check_code(input int v, input string tag);
        logic [NN-1:0] e;
        e = expect_word(v);
        checks++;
        if (d !== e) begin
          fails++;
          $display("FAIL %s N=%0d addr=%0d data actual=%b expected=%b", tag, NN, v, d, e);
        end
        checks++;
        if (dn !== ~e) begin
          fails++;
          $display("FAIL R4 N=%0d addr=%0d data_n actual=%b expected=%b", NN, v, dn, ~e);
        end
        if (NN > 1) begin
          checks++;
          if ($countones(d) != 1) begin
            fails++;
            $display("FAIL R6 N=%0d addr=%0d ones actual=%0d expected=1", NN, v, $countones(d));
          end
        end
      endtask

      initial begin
        // Width of the selector port (R1)
        checks++;
        if ($bits(dut.addr_i) != AW) begin
          fails++;
          $display("FAIL R1 N=%0d width actual=%0d expected=%0d", NN, $bits(dut.addr_i), AW);
        end
        // Initial state with the selector at zero
        @(negedge clk);
        #1 check_code(0, (NN == 1) ? "R5" : "R2");
        // Every encodable selector value (R2, R3, R5)
        for (int v = 0; v < (1 << AW); v++) begin
          @(negedge clk);
          a = v[AW-1:0];
          #1 check_code(v, (NN == 1) ? "R5" : ((v < NN) ? "R2" : "R3"));
        end
        // Apply codes again in reverse order: same result, same cycle (R7)
        for (int v = (1 << AW) - 1; v >= 0; v--) begin
          @(negedge clk);
          a = v[AW-1:0];
          #1 check_code(v, "R7");
        end
        done[g] = 1'b1;
      end
    end
  endgenerate

  initial begin
    wait (&done);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule